// File: doc/BRIEF.md
# Cascaded Programmable Interrupt Controller

This block joins two eight-line interrupt controllers into a sixteen-line interrupt source for a processor. The secondary controller collects lines 8 to 15. Its request output drives line 2 of the primary controller. The primary's request output is the block's single interrupt line to the processor. Each controller has three byte registers on a small write/read register bus: a control register, a data register and a trigger-select register.

Software brings each controller up with a control write that has bit 4 set, for example 0x11. The next three data writes are then taken as the vector base, the cascade word and the mode word. After the third word the data register reads and writes the line mask. Each line is edge or level sensitive, as its trigger-select bit chooses.

Priority is fixed and fully nested. When the processor acknowledges, the winning line moves into service and an interrupt vector number is presented. A non-specific end-of-interrupt command retires the most important line in service. For a line on the secondary, that command goes first to the secondary and then to the primary.

Top module: `cascaded_pic`

## Requirements
- R1: Until a controller has been initialized, it never raises a request. Data-register writes to it are ignored, so its mask keeps reading 0xFF.
- R2: After reset both masks read 0xFF, both trigger-select registers read 0x00, and int_req and vec_valid are 0.
- R3: A control write with bit 4 set starts initialization. It clears that controller's mask to 0x00 and its in-service state. The next three data writes are the vector base, the cascade word and the mode word, in that order. Later data writes and reads access the mask.
- R4: The low three bits of the vector base are dropped. The vector for a line is the base plus the line's index within its controller, so lines 8 to 15 give the secondary base plus 0 to 7.
- R5: A mask bit of 1 stops that line from raising int_req or winning an acknowledge.
- R6: A trigger-select bit of 0 makes the line edge sensitive. A rising input latches a request, and the acknowledge of that line consumes it, so an input held high does not request again. A bit of 1 makes the line level sensitive, following the live input.
- R7: Within a controller, the lower line index has the higher priority. A request is forwarded only if no line of equal or higher priority is in service.
- R8: An int_ack pulse gives vec_valid high for exactly the next cycle, with the vector on vec_num. The winning line becomes in service.
- R9: Primary line 2 is driven only by the secondary's request, and the external irq_in[2] has no effect. When the primary's cascade word has bit 2 set and line 2 wins, the secondary supplies the vector and marks its own line in service.
- R10: A control write of 0x20 clears the highest-priority in-service line of that controller. A control write with bit 4 clear and any other value changes nothing.
- R11: An acknowledge with no eligible request returns the primary base plus 7 and marks no line in service.
- R12: Address bit 2 selects the controller, with 0 for the primary. Address bits 1:0 select control (0), data (1) or trigger-select (2). Reads are combinational, and control and unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address: controller select and register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_in | input | 16 | Interrupt request lines; bit 2 is unused |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector valid, the cycle after an acknowledge |
| vec_num | output | 8 | Interrupt vector number |

## Verification
The in-service assertions assume that an acknowledge never lands in the same cycle as an end-of-interrupt write to the same controller, so each update they check has a single cause. They also assume that int_ack is a single-cycle pulse. The bench issues every acknowledge and every register write from separate tasks, each aligned to its own falling edge, so the two never overlap. Request lines change only between acknowledges, and a level line is not dropped during the cycle in which it is acknowledged.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [2:0] {
      PS_UNINIT,
      PS_BASE,
      PS_CASC,
      PS_MODE,
      PS_READY
   } pic_state_e;

   localparam int unsigned INIT_BIT = 4;
   localparam logic [7:0]  CMD_EOI  = 8'h20;

   localparam logic [1:0]  REG_CTRL = 2'd0;
   localparam logic [1:0]  REG_DATA = 2'd1;
   localparam logic [1:0]  REG_TRIG = 2'd2;
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
   parameter int unsigned LINES       = 8,
   parameter logic [LINES-1:0] FORCE_LEVEL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [LINES-1:0] line_i,
   input  logic [LINES-1:0] level_i,
   input  logic [LINES-1:0] ack_onehot_i,
   output logic [LINES-1:0] irr_o
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic prev_q;
      logic latch_q;
      logic is_level;

      assign is_level = level_i[i] | FORCE_LEVEL[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
         end else begin
            prev_q <= line_i[i];
            if (clr_i || is_level) begin
               latch_q <= 1'b0;
            end else if (line_i[i] && !prev_q) begin
               latch_q <= 1'b1;
            end else if (ack_onehot_i[i]) begin
               latch_q <= 1'b0;
            end
         end
      end

      assign irr_o[i] = is_level ? line_i[i] : latch_q;

      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!is_level && latch_q && !ack_onehot_i[i] && !clr_i) |=> latch_q); // R6
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int unsigned LINES = 8,
   localparam int unsigned IDXW = $clog2(LINES)
) (
   input  logic [LINES-1:0] pend_i,
   input  logic [LINES-1:0] isr_i,
   output logic [IDXW-1:0]  win_idx_o,
   output logic             win_valid_o,
   output logic [IDXW-1:0]  top_idx_o,
   output logic             top_any_o
);
   logic [IDXW-1:0] win;
   logic            found;
   logic            blocked;

   always_comb begin
      win       = '0;
      found     = 1'b0;
      top_idx_o = '0;
      top_any_o = 1'b0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            win   = IDXW'(i);
            found = 1'b1;
         end
         if (isr_i[i]) begin
            top_idx_o = IDXW'(i);
            top_any_o = 1'b1;
         end
      end
      blocked = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         if (isr_i[i] && (IDXW'(i) <= win)) blocked = 1'b1;
      end
   end

   assign win_idx_o   = win;
   assign win_valid_o = found && !blocked;
endmodule

// File: rtl/pic_unit.sv
module pic_unit
   import pic_pkg::*;
#(
   parameter int unsigned LINES     = 8,
   parameter int unsigned BUS_W     = 8,
   parameter bit          HAS_CASC  = 1'b0,
   parameter int unsigned CASC_LINE = 2,
   localparam int unsigned IDXW     = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl_i,
   input  logic             wr_data_i,
   input  logic             wr_trig_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [LINES-1:0] lines_i,
   input  logic             ack_i,
   output logic [LINES-1:0] mask_o,
   output logic [LINES-1:0] trig_o,
   output logic             int_o,
   output logic [BUS_W-1:0] vec_o,
   output logic             deleg_o
);
   if (LINES < 2 || LINES > BUS_W) begin : g_bad_lines
      $error("pic_unit: LINES must lie between 2 and BUS_W");
   end
   if ((LINES & (LINES - 1)) != 0) begin : g_bad_pow2
      $error("pic_unit: LINES must be a power of two");
   end
   if (HAS_CASC && CASC_LINE >= LINES) begin : g_bad_casc
      $error("pic_unit: CASC_LINE out of range");
   end

   localparam logic [LINES-1:0] FORCE_LVL =
      HAS_CASC ? (LINES'(1) << CASC_LINE) : '0;

   pic_state_e       state_q;
   logic [BUS_W-1:0] base_q;
   logic [LINES-1:0] mask_q;
   logic [LINES-1:0] trig_q;
   logic [LINES-1:0] isr_q;
   logic [LINES-1:0] isr_nxt;
   logic [LINES-1:0] irr;
   logic [LINES-1:0] pend;
   logic [LINES-1:0] ack_onehot;
   logic [IDXW-1:0]  win_idx;
   logic [IDXW-1:0]  top_idx;
   logic [IDXW-1:0]  vec_idx;
   logic             win_valid;
   logic             top_any;
   logic             ready;
   logic             init_cmd;
   logic             eoi_cmd;
   logic             ack_eff;
   logic             deleg_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i;

   assign ready    = (state_q == PS_READY);
   assign init_cmd = wr_ctrl_i && wdata_i[INIT_BIT];
   assign eoi_cmd  = wr_ctrl_i && (wdata_i == BUS_W'(CMD_EOI)) && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PS_UNINIT;
      end else if (init_cmd) begin
         state_q <= PS_BASE;
      end else if (wr_data_i) begin
         case (state_q)
            PS_BASE: state_q <= PS_CASC;
            PS_CASC: state_q <= PS_MODE;
            PS_MODE: state_q <= PS_READY;
            default: state_q <= state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_data_i && state_q == PS_BASE) begin
         base_q <= {wdata_i[BUS_W-1:IDXW], {IDXW{1'b0}}};
      end
   end

   if (HAS_CASC) begin : g_casc
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            deleg_q <= 1'b0;
         end else if (init_cmd) begin
            deleg_q <= 1'b0;
         end else if (wr_data_i && state_q == PS_CASC) begin
            deleg_q <= wdata_i[CASC_LINE];
         end
      end
   end else begin : g_no_casc
      assign deleg_q = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (init_cmd) begin
         mask_q <= '0;
      end else if (wr_data_i && ready) begin
         mask_q <= wdata_i[LINES-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= '0;
      end else if (wr_trig_i) begin
         trig_q <= wdata_i[LINES-1:0];
      end
   end

   pic_req_capture #(
      .LINES      (LINES),
      .FORCE_LEVEL(FORCE_LVL)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (init_cmd),
      .line_i      (lines_i),
      .level_i     (trig_q),
      .ack_onehot_i(ack_onehot),
      .irr_o       (irr)
   );

   assign pend = irr & ~mask_q;

   pic_prio #(.LINES(LINES)) u_prio (
      .pend_i     (pend),
      .isr_i      (isr_q),
      .win_idx_o  (win_idx),
      .win_valid_o(win_valid),
      .top_idx_o  (top_idx),
      .top_any_o  (top_any)
   );

   assign ack_eff    = ack_i && ready && win_valid;
   assign ack_onehot = ack_eff ? (LINES'(1) << win_idx) : '0;

   always_comb begin
      isr_nxt = isr_q;
      if (ack_eff) isr_nxt[win_idx] = 1'b1;
      if (eoi_cmd && top_any) isr_nxt[top_idx] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else if (init_cmd) begin
         isr_q <= '0;
      end else begin
         isr_q <= isr_nxt;
      end
   end

   assign vec_idx = win_valid ? win_idx : IDXW'(LINES - 1);
   assign vec_o   = base_q | {{(BUS_W-IDXW){1'b0}}, vec_idx};
   assign int_o   = ready && win_valid;
   assign deleg_o = deleg_q && win_valid && (win_idx == IDXW'(CASC_LINE));
   assign mask_o  = mask_q;
   assign trig_o  = trig_q;

   AST_UNINIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_UNINIT) |-> (mask_q == '1)); // R1
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_cmd |=> (mask_q == '0 && isr_q == '0)); // R3
   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> !mask_q[win_idx]); // R5
   AST_NESTED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> !isr_q[win_idx]); // R7
   AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_eff && !eoi_cmd) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R8
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_cmd && isr_q != '0 && !ack_eff) |=> ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R10
endmodule

// File: rtl/cascaded_pic.sv
module cascaded_pic
   import pic_pkg::*;
#(
   parameter int unsigned LINES     = 8,
   parameter int unsigned BUS_W     = 8,
   parameter int unsigned CASC_LINE = 2,
   localparam int unsigned TOT      = 2 * LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [TOT-1:0]   irq_in,
   output logic             int_req,
   input  logic             int_ack,
   output logic             vec_valid,
   output logic [BUS_W-1:0] vec_num
);
   if (CASC_LINE >= LINES) begin : g_bad_casc
      $error("cascaded_pic: CASC_LINE out of range");
   end

   logic [LINES-1:0] m_lines, s_lines;
   logic [LINES-1:0] m_mask, s_mask, m_trig, s_trig;
   logic [BUS_W-1:0] m_vec, s_vec;
   logic             m_int, s_int, m_deleg, s_deleg;
   logic             s_ack;
   logic [1:0]       reg_sel;
   logic             unit_sel;
   logic [1:0]       wr_ctrl, wr_data, wr_trig;
   logic [BUS_W-1:0] vec_q;
   logic             vld_q;
   logic             unused_sdeleg;

   assign reg_sel  = bus_addr[1:0];
   assign unit_sel = bus_addr[2];

   for (genvar u = 0; u < 2; u++) begin : g_dec
      assign wr_ctrl[u] = bus_wr && (unit_sel == u[0]) && (reg_sel == REG_CTRL);
      assign wr_data[u] = bus_wr && (unit_sel == u[0]) && (reg_sel == REG_DATA);
      assign wr_trig[u] = bus_wr && (unit_sel == u[0]) && (reg_sel == REG_TRIG);
   end

   always_comb begin
      m_lines            = irq_in[LINES-1:0];
      m_lines[CASC_LINE] = s_int;
   end
   assign s_lines = irq_in[TOT-1:LINES];

   pic_unit #(
      .LINES(LINES), .BUS_W(BUS_W), .HAS_CASC(1'b1), .CASC_LINE(CASC_LINE)
   ) u_primary (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl_i(wr_ctrl[0]), .wr_data_i(wr_data[0]), .wr_trig_i(wr_trig[0]),
      .wdata_i(bus_wdata), .lines_i(m_lines), .ack_i(int_ack),
      .mask_o(m_mask), .trig_o(m_trig), .int_o(m_int),
      .vec_o(m_vec), .deleg_o(m_deleg)
   );

   assign s_ack = int_ack && m_deleg;

   pic_unit #(
      .LINES(LINES), .BUS_W(BUS_W), .HAS_CASC(1'b0), .CASC_LINE(CASC_LINE)
   ) u_secondary (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl_i(wr_ctrl[1]), .wr_data_i(wr_data[1]), .wr_trig_i(wr_trig[1]),
      .wdata_i(bus_wdata), .lines_i(s_lines), .ack_i(s_ack),
      .mask_o(s_mask), .trig_o(s_trig), .int_o(s_int),
      .vec_o(s_vec), .deleg_o(s_deleg)
   );

   assign unused_sdeleg = s_deleg;

   always_comb begin
      case (reg_sel)
         REG_DATA: bus_rdata = BUS_W'(unit_sel ? s_mask : m_mask);
         REG_TRIG: bus_rdata = BUS_W'(unit_sel ? s_trig : m_trig);
         default:  bus_rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         vec_q <= '0;
      end else begin
         vld_q <= int_ack;
         if (int_ack) vec_q <= m_deleg ? s_vec : m_vec;
      end
   end

   assign int_req   = m_int;
   assign vec_valid = vld_q;
   assign vec_num   = vec_q;

   AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> vec_valid); // R8
   AST_VEC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |=> !vec_valid); // R8
   AST_SLAVE_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      s_ack |-> s_int); // R9
endmodule

// File: tb/cascaded_pic_tb.sv
module cascaded_pic_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] irq_in = '0;
   logic        int_req;
   logic        int_ack = 1'b0;
   logic        vec_valid;
   logic [7:0]  vec_num;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cascaded_pic u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid), .vec_num(vec_num)
   );

   // entry: {trig[15:0], mask[15:0], irq[15:0], exp_int, exp_vec[7:0]}
   localparam int NT = 10;
   localparam logic [56:0] TBL [NT] = '{
      {16'hFFFF, 16'h0000, 16'h0001, 1'b1, 8'h40},
      {16'hFFFF, 16'h0000, 16'h0030, 1'b1, 8'h44},
      {16'hFFFF, 16'h0010, 16'h0030, 1'b1, 8'h45},
      {16'hFFFF, 16'h0000, 16'h0100, 1'b1, 8'h48},
      {16'hFFFF, 16'h0000, 16'h8080, 1'b1, 8'h4F},
      {16'hFFFF, 16'h8000, 16'h8080, 1'b1, 8'h47},
      {16'hFFFF, 16'h0000, 16'h0004, 1'b0, 8'h00},
      {16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 8'h00},
      {16'hFBFF, 16'h0000, 16'h0400, 1'b1, 8'h4A},
      {16'hFFFF, 16'h0002, 16'h0002, 1'b0, 8'h00}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ack(output logic v, output logic [7:0] n);
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      #1 v = vec_valid; n = vec_num;
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
      #1;
   endtask

   task automatic init_unit(input logic s, input logic [7:0] base, input logic [7:0] casc);
      wr({s, 2'd0}, 8'h11);
      wr({s, 2'd1}, base);
      wr({s, 2'd1}, casc);
      wr({s, 2'd1}, 8'h01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic v;
      repeat (3) @(negedge clk);
      #1;
      check("R2 int_req reset", int_req, 0);
      check("R2 vec_valid reset", vec_valid, 0);
      rst_n = 1'b1;
      rd(3'b001, d); check("R2 primary mask reset", d, 8'hFF);
      rd(3'b101, d); check("R2 secondary mask reset", d, 8'hFF);
      rd(3'b010, d); check("R2 primary trig reset", d, 8'h00);
      rd(3'b110, d); check("R2 secondary trig reset", d, 8'h00);

      // R1: uninitialized controller ignores data writes and stays quiet
      wr(3'b001, 8'h00);
      rd(3'b001, d); check("R1 mask write ignored", d, 8'hFF);
      wr(3'b010, 8'hFF);
      irq_in = 16'h0001;
      settle(); check("R1 no request before init", int_req, 0);
      irq_in = '0;

      // R3/R4: init, base 0x43 aligns to 0x40
      init_unit(1'b0, 8'h43, 8'h04);
      init_unit(1'b1, 8'h48, 8'h02);
      rd(3'b001, d); check("R3 mask cleared by init", d, 8'h00);
      wr(3'b001, 8'hA5);
      rd(3'b001, d); check("R3 mask readback", d, 8'hA5);
      init_unit(1'b0, 8'h43, 8'h04);
      rd(3'b001, d); check("R3 reinit clears mask", d, 8'h00);

      // R12: address map
      wr(3'b110, 8'h3C);
      rd(3'b110, d); check("R12 secondary trig readback", d, 8'h3C);
      rd(3'b010, d); check("R12 primary trig untouched", d, 8'hFF);
      rd(3'b000, d); check("R12 control reads zero", d, 8'h00);

      // vector table: R4 R5 R6 R7 R9
      for (int i = 0; i < NT; i++) begin
         logic [56:0] e;
         e = TBL[i];
         irq_in = '0;
         wr(3'b010, e[48:41]); wr(3'b110, e[56:49]);
         wr(3'b001, e[32:25]); wr(3'b101, e[40:33]);
         settle();
         irq_in = e[24:9];
         settle();
         check($sformatf("R5 R7 R9 table[%0d] int_req", i), int_req, int'(e[8]));
         if (e[8]) begin
            ack(v, d);
            check($sformatf("R8 table[%0d] vec_valid", i), v, 1);
            check($sformatf("R4 R6 table[%0d] vector", i), d, e[7:0]);
            if (d >= 8'h48) wr(3'b100, 8'h20);
            wr(3'b000, 8'h20);
         end
         irq_in = '0;
      end

      // R7 nesting, all level lines, no masks
      wr(3'b010, 8'hFF); wr(3'b110, 8'hFF);
      wr(3'b001, 8'h00); wr(3'b101, 8'h00);
      irq_in = 16'h0008; settle();
      ack(v, d); check("R7 first vector", d, 8'h43);
      irq_in = 16'h000A; settle();
      check("R7 higher line preempts", int_req, 1);
      ack(v, d); check("R7 nested vector", d, 8'h41);
      irq_in = 16'h002A; settle();
      check("R7 lower line blocked", int_req, 0);
      irq_in = 16'h0028;
      wr(3'b000, 8'h20); settle();
      check("R10 eoi retires only top line", int_req, 0);
      wr(3'b000, 8'h20); settle();
      check("R10 second eoi reopens line 3", int_req, 1);
      irq_in = 16'h0020; settle();
      ack(v, d); check("R7 line 5 vector", d, 8'h45);
      wr(3'b000, 8'h0A); settle();
      check("R10 other control value ignored", int_req, 0);
      wr(3'b000, 8'h20); settle();
      check("R10 eoi after ignored write", int_req, 1);
      irq_in = '0; settle();

      // R6: edge request consumed by acknowledge
      wr(3'b010, 8'hBF);
      irq_in = 16'h0040; settle();
      check("R6 edge request raised", int_req, 1);
      ack(v, d); check("R6 edge vector", d, 8'h46);
      wr(3'b000, 8'h20); settle();
      check("R6 held edge input not requeued", int_req, 0);
      irq_in = '0;
      wr(3'b010, 8'hFF); settle();

      // R9: secondary in-service bit set on delegated acknowledge
      irq_in = 16'h0200; settle();
      ack(v, d); check("R9 secondary vector", d, 8'h49);
      wr(3'b000, 8'h20); settle();
      check("R9 secondary in service blocks", int_req, 0);
      wr(3'b100, 8'h20); settle();
      check("R9 secondary eoi reopens", int_req, 1);
      ack(v, d);
      wr(3'b100, 8'h20); wr(3'b000, 8'h20);
      irq_in = '0; settle();

      // R11: spurious acknowledge
      ack(v, d);
      check("R11 spurious valid", v, 1);
      check("R11 spurious vector", d, 8'h47);
      irq_in = 16'h0080; settle();
      check("R11 no line set in service", int_req, 1);
      irq_in = '0; settle();
      check("R8 vec_valid drops", vec_valid, 0);

      finish_run();
   end
endmodule